// File: doc/BRIEF.md
# Clock Victim Frame Selector

This block chooses which physical frame to evict when a new page must be brought in. It applies the not-recently-used clock policy. Each frame has a used flag and a dirty flag. Memory accesses report into the block: every reference sets the frame's used flag, and a store also sets its dirty flag. A pointer records the frame that was evicted last.

When a replacement is requested, the block walks forward from that pointer one frame per clock cycle, wrapping at the end of the table. Each frame it passes over has its used flag cleared, so a frame that is not touched again becomes eligible on the next lap. The walk stops at the first eligible frame. The block then returns that frame's index with a one-cycle done pulse, reports whether the frame was dirty (so the caller knows a writeback is due), and leaves the pointer on that frame.

A per-request mode bit selects one of two eligibility rules. In the default rule, any unused frame is eligible. In the clean rule, a frame must be both unused and clean. If a whole lap in clean rule finds no such frame, the block settles for the first unused frame it passed.

Top module: `nru_victim_picker`

## Requirements
- R1: After a synchronous active-low reset, the pointer is at frame 0, every used and dirty flag is 0, and busy and done are low. The first request after reset therefore examines frame 1 first.
- R2: A reference report (`ref_valid`) sets the used flag of `ref_frame` on the next clock edge. If `ref_store` is 1 at the same time, the dirty flag of that frame is also set.
- R3: A request (`pick_req`) taken while idle raises `busy` on the next edge. The walk begins at pointer+1 (frame N-1 wraps to 0) and examines exactly one frame per cycle.
- R4: With `pick_clean` low at request time, the first examined frame whose used flag is 0 is selected. On the edge after the cycle that examined it, `pick_done` rises, `pick_frame` holds its index, `busy` falls, and the pointer moves to it.
- R5: Every examined frame has its used flag cleared. When all frames start out used, a default-rule request selects pointer+1 after N+1 examined frames.
- R6: With `pick_clean` high at request time, the first examined frame with both flags 0 is selected.
- R7: In clean rule, if N frames have been examined without finding an unused clean frame, the first unused frame seen during the walk is selected. If no unused frame was seen, the walk continues for another lap under the same rule.
- R8: A reference to a frame in the same cycle that the walk clears that frame's used flag wins, so the flag stays 1.
- R9: `pick_dirty` gives the dirty flag the selected frame had when it was chosen. The selected frame's dirty flag is cleared at selection, unless a store to that frame is reported in the same cycle.
- R10: A request that arrives while `busy` is high is ignored.
- R11: `pick_done` is high for exactly one cycle per selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | Reference report valid |
| ref_frame | input | IDX_W | Frame being referenced |
| ref_store | input | 1 | Reference is a store (also marks the frame dirty) |
| pick_req | input | 1 | Request a victim (ignored while busy) |
| pick_clean | input | 1 | Clean rule for this request: victim must also be clean |
| busy | output | 1 | Walk in progress |
| pick_done | output | 1 | One-cycle pulse: victim chosen |
| pick_frame | output | IDX_W | Index of the chosen frame |
| pick_dirty | output | 1 | Chosen frame was dirty when selected |

## Verification
The assertions assume that `ref_frame` is always below the frame count whenever `ref_valid` is high. They also assume that `pick_req` and `pick_clean` are stable, known values at each clock edge. The stimulus draws frame indices modulo the frame count, so no out-of-range index is ever reported. Requests are issued both while idle and during a walk; the walk is free to run any number of laps, because a clean-rule search over frames that are all dirty legitimately needs a second lap. A cycle-level reference model in the bench follows every report and request, so referencing a frame at the moment it is examined is covered both directly and in the random phase.

// File: rtl/nru_pkg.sv
// Package: shared types for the clock victim selector.
// Assumes nothing beyond IEEE 1800-2017 packages.
package nru_pkg;
    // Walk controller state
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;
endpackage

// File: rtl/nru_frame_flags.sv
// Module: per-frame used/dirty flag storage.
// Reference reports set flags. The walk clears used flags, and selection
// clears the victim's dirty flag. A report always beats a clear in the same
// cycle. Assumes ref_frame < NUM_FRAMES whenever ref_valid is high.
module nru_frame_flags #(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_valid,
    input  logic [IDX_W-1:0]      ref_frame,
    input  logic                  ref_store,
    input  logic                  scan_clr,
    input  logic [IDX_W-1:0]      scan_idx,
    input  logic                  take_en,
    input  logic [IDX_W-1:0]      take_idx,
    output logic [NUM_FRAMES-1:0] used_vec,
    output logic [NUM_FRAMES-1:0] dirty_vec
);
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        logic used_q;
        logic dirty_q;
        logic hit_ref;
        logic hit_scan;
        logic hit_take;

        assign hit_ref  = ref_valid && (ref_frame == IDX_W'(i));
        assign hit_scan = scan_clr  && (scan_idx  == IDX_W'(i));
        assign hit_take = take_en   && (take_idx  == IDX_W'(i));

        // Used flag: a reference sets it and wins over the walk's clear
        always_ff @(posedge clk) begin
            if (!rst_n)        used_q <= 1'b0;
            else if (hit_ref)  used_q <= 1'b1;
            else if (hit_scan) used_q <= 1'b0;
        end

        // Dirty flag: a store sets it and wins over the clear at selection
        always_ff @(posedge clk) begin
            if (!rst_n)                     dirty_q <= 1'b0;
            else if (hit_ref && ref_store)  dirty_q <= 1'b1;
            else if (hit_take)              dirty_q <= 1'b0;
        end

        assign used_vec[i]  = used_q;
        assign dirty_vec[i] = dirty_q;
    end

    // R2 and R8: a reported reference always leaves the used flag set
    a_r2_ref_sets_used: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> used_vec[$past(ref_frame)]);

    // R2: a reported store always leaves the dirty flag set
    a_r2_store_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_store) |=> dirty_vec[$past(ref_frame)]);

    // R5: a walked frame with no concurrent reference ends up unused
    a_r5_walk_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_clr && !(ref_valid && ref_frame == scan_idx)) |=> !used_vec[$past(scan_idx)]);
endmodule

// File: rtl/nru_walk_ctrl.sv
// Module: clock-hand walk controller.
// Holds the last-replaced pointer. Examines one frame per cycle from
// pointer+1, records the first unused frame for the clean-rule fallback,
// and emits a registered selection pulse. Assumes the flag vectors come
// from registers (one cycle of flag state per examined frame).
module nru_walk_ctrl
    import nru_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pick_req,
    input  logic                  pick_clean,
    input  logic [NUM_FRAMES-1:0] used_vec,
    input  logic [NUM_FRAMES-1:0] dirty_vec,
    output logic                  scan_clr,
    output logic [IDX_W-1:0]      scan_idx,
    output logic                  take_en,
    output logic [IDX_W-1:0]      take_idx,
    output logic                  busy,
    output logic                  pick_done,
    output logic [IDX_W-1:0]      pick_frame,
    output logic                  pick_dirty
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

    walk_state_e      state_q;
    logic [IDX_W-1:0] hand_q;
    logic [IDX_W-1:0] probe_q;
    logic [IDX_W-1:0] lap_cnt_q;
    logic             fb_valid_q;
    logic [IDX_W-1:0] fb_idx_q;
    logic             clean_q;
    logic             done_q;
    logic [IDX_W-1:0] frame_q;
    logic             dirty_q;

    logic             cur_used;
    logic             cur_dirty;
    logic             hit;
    logic             lap_end;
    logic             use_fb;
    logic [IDX_W-1:0] sel_idx;
    logic [IDX_W-1:0] probe_next;
    logic [IDX_W-1:0] hand_next;

    // Walk-cycle decode: decide whether this frame ends the search
    always_comb begin
        cur_used   = used_vec[probe_q];
        cur_dirty  = dirty_vec[probe_q];
        hit        = !cur_used && (!clean_q || !cur_dirty);
        lap_end    = (lap_cnt_q == LAST);
        use_fb     = clean_q && !hit && lap_end && (fb_valid_q || !cur_used);
        sel_idx    = hit ? probe_q : (fb_valid_q ? fb_idx_q : probe_q);
        probe_next = (probe_q == LAST) ? '0 : probe_q + 1'b1;
        hand_next  = (hand_q  == LAST) ? '0 : hand_q  + 1'b1;
    end

    assign scan_clr = (state_q == ST_WALK);
    assign scan_idx = probe_q;
    assign take_en  = (state_q == ST_WALK) && (hit || use_fb);
    assign take_idx = sel_idx;

    // State, pointer and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hand_q     <= '0;
            probe_q    <= '0;
            lap_cnt_q  <= '0;
            fb_valid_q <= 1'b0;
            fb_idx_q   <= '0;
            clean_q    <= 1'b0;
            done_q     <= 1'b0;
            frame_q    <= '0;
            dirty_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (pick_req) begin
                    state_q    <= ST_WALK;
                    probe_q    <= hand_next;
                    lap_cnt_q  <= '0;
                    fb_valid_q <= 1'b0;
                    clean_q    <= pick_clean;
                end
            end else if (take_en) begin
                state_q <= ST_IDLE;
                hand_q  <= sel_idx;
                done_q  <= 1'b1;
                frame_q <= sel_idx;
                dirty_q <= dirty_vec[sel_idx];
            end else begin
                probe_q   <= probe_next;
                lap_cnt_q <= lap_end ? '0 : lap_cnt_q + 1'b1;
                if (clean_q && !cur_used && !fb_valid_q) begin
                    fb_valid_q <= 1'b1;
                    fb_idx_q   <= probe_q;
                end
            end
        end
    end

    assign busy       = (state_q == ST_WALK);
    assign pick_done  = done_q;
    assign pick_frame = frame_q;
    assign pick_dirty = dirty_q;

    // R11: selection pulse lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pick_done |=> !pick_done);

    // R3: a walk only starts from a request
    a_r3_walk_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pick_req));

    // R4: a default-rule victim had its used flag clear when examined
    a_r4_victim_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_done && !clean_q) |-> !$past(cur_used));

    // R4: the pointer rests on the reported victim
    a_r4_hand_on_victim: assert property (@(posedge clk) disable iff (!rst_n)
        pick_done |-> (hand_q == pick_frame) && (pick_frame <= LAST));

    // R10: a request during a walk does not restart it
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pick_req && !take_en) |=> (busy && lap_cnt_q != '0) || $past(lap_end));
endmodule

// File: rtl/nru_victim_picker.sv
// Module: top of the clock victim selector.
// Joins the per-frame flag store with the walk controller.
// Assumes NUM_FRAMES >= 8.
module nru_victim_picker #(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             ref_store,
    input  logic             pick_req,
    input  logic             pick_clean,
    output logic             busy,
    output logic             pick_done,
    output logic [IDX_W-1:0] pick_frame,
    output logic             pick_dirty
);
    logic [NUM_FRAMES-1:0] used_vec;
    logic [NUM_FRAMES-1:0] dirty_vec;
    logic                  scan_clr;
    logic [IDX_W-1:0]      scan_idx;
    logic                  take_en;
    logic [IDX_W-1:0]      take_idx;

    nru_frame_flags #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_valid (ref_valid),
        .ref_frame (ref_frame),
        .ref_store (ref_store),
        .scan_clr  (scan_clr),
        .scan_idx  (scan_idx),
        .take_en   (take_en),
        .take_idx  (take_idx),
        .used_vec  (used_vec),
        .dirty_vec (dirty_vec)
    );

    nru_walk_ctrl #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_req   (pick_req),
        .pick_clean (pick_clean),
        .used_vec   (used_vec),
        .dirty_vec  (dirty_vec),
        .scan_clr   (scan_clr),
        .scan_idx   (scan_idx),
        .take_en    (take_en),
        .take_idx   (take_idx),
        .busy       (busy),
        .pick_done  (pick_done),
        .pick_frame (pick_frame),
        .pick_dirty (pick_dirty)
    );

    // R1: outputs quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !pick_done));
endmodule

// File: tb/nru_victim_picker_test.sv
// Bench: directed corner cases, then seeded random traffic, checked against
// a cycle-level reference model built from the requirements.
module nru_victim_picker_test;
    localparam int N = 16;
    localparam int W = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_valid = 1'b0;
    logic [W-1:0] ref_frame = '0;
    logic         ref_store = 1'b0;
    logic         pick_req = 1'b0;
    logic         pick_clean = 1'b0;
    logic         busy;
    logic         pick_done;
    logic [W-1:0] pick_frame;
    logic         pick_dirty;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model state
    bit m_used [N];
    bit m_dirty[N];
    int m_hand = 0;
    bit m_walk = 0;
    int m_probe = 0;
    int m_cnt = 0;
    bit m_fbv = 0;
    int m_fb = 0;
    bit m_mode = 0;
    bit e_done = 0;
    int e_frame = 0;
    bit e_dirty = 0;
    // last observed selection
    int last_frame = 0;
    bit last_dirty = 0;

    always #10 clk = ~clk;

    nru_victim_picker #(.NUM_FRAMES(N)) uut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
        .ref_store(ref_store), .pick_req(pick_req), .pick_clean(pick_clean),
        .busy(busy), .pick_done(pick_done), .pick_frame(pick_frame), .pick_dirty(pick_dirty)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int nxt(input int f);
        return (f + 1) % N;
    endfunction

    // Model one clock edge for the given inputs
    task automatic model_edge(input bit rv, input int ri, input bit rw, input bit rq, input bit rm);
        bit nu[N];
        bit nd[N];
        for (int i = 0; i < N; i++) begin nu[i] = m_used[i]; nd[i] = m_dirty[i]; end
        e_done = 0;
        if (!m_walk) begin
            if (rq) begin
                m_walk = 1; m_probe = nxt(m_hand); m_cnt = 0; m_fbv = 0; m_mode = rm;
            end
        end else begin
            int f = m_probe;
            bit u = m_used[f];
            bit d = m_dirty[f];
            bit h = !u && (!m_mode || !d);
            bit le = (m_cnt == N - 1);
            bit pf = m_mode && !h && le && (m_fbv || !u);
            nu[f] = 0;
            if (h || pf) begin
                int s = h ? f : (m_fbv ? m_fb : f);
                e_done = 1; e_frame = s; e_dirty = m_dirty[s];
                nd[s] = 0; m_hand = s; m_walk = 0;
            end else begin
                if (m_mode && !u && !m_fbv) begin m_fb = f; m_fbv = 1; end
                m_probe = nxt(f);
                m_cnt = le ? 0 : m_cnt + 1;
            end
        end
        if (rv) begin nu[ri] = 1; if (rw) nd[ri] = 1; end
        for (int i = 0; i < N; i++) begin m_used[i] = nu[i]; m_dirty[i] = nd[i]; end
    endtask

    // Drive one cycle at the falling edge, then compare after the next rising edge
    task automatic step(input bit rv, input int ri, input bit rw, input bit rq, input bit rm);
        ref_valid = rv; ref_frame = W'(ri); ref_store = rw;
        pick_req = rq; pick_clean = rm;
        model_edge(rv, ri, rw, rq, rm);
        @(negedge clk);
        check(tag, int'(pick_done), int'(e_done), "done");
        check(tag, int'(busy), int'(m_walk), "busy");
        if (e_done) begin
            check(tag, int'(pick_frame), e_frame, "frame");
            check(tag, int'(pick_dirty), int'(e_dirty), "dirty");
            last_frame = int'(pick_frame);
            last_dirty = pick_dirty;
        end
    endtask

    task automatic idle_until_done();
        int guard = 0;
        while (m_walk && guard < 4 * N + 8) begin
            step(0, 0, 0, 0, 0);
            guard++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_used[i] = 0; m_dirty[i] = 0; end
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check("R1", int'(busy), 0, "busy after reset");
        check("R1", int'(pick_done), 0, "done after reset");

        // R1 R3 R4: first request examines frame 1, which is unused
        tag = "R3 R4";
        step(0, 0, 0, 1, 0);
        check("R3", int'(busy), 1, "busy after request");
        idle_until_done();
        check("R1", last_frame, 1, "first victim");

        // R5: all frames used; the walk clears all and takes pointer+1
        tag = "R5";
        for (int i = 0; i < N; i++) step(1, i, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        idle_until_done();
        check("R5", last_frame, 2, "victim after full lap");

        // R7: all frames dirty and used; clean rule falls back on second lap
        tag = "R7";
        for (int i = 0; i < N; i++) step(1, i, 1, 0, 0);
        step(0, 0, 0, 1, 1);
        idle_until_done();
        check("R7", last_frame, 3, "fallback victim");
        check("R9", int'(last_dirty), 1, "fallback was dirty");

        // R6 R9: only frame 3 is clean; clean rule walks a full lap to reach it
        tag = "R6";
        step(0, 0, 0, 1, 1);
        idle_until_done();
        check("R6", last_frame, 3, "clean victim");
        check("R9", int'(last_dirty), 0, "dirty cleared at selection");

        // R8: reference to the frame under examination keeps it used
        tag = "R8";
        for (int i = 0; i < N; i++) step(1, i, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(1, 4, 0, 0, 0);
        idle_until_done();
        check("R8", last_frame, 5, "referenced frame skipped");

        // R10: requests during a walk are ignored
        tag = "R10";
        for (int i = 0; i < N; i++) step(1, i, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1);
        idle_until_done();
        check("R10", last_frame, 6, "walk not restarted");

        // R2 R4 R6 R7 R9 R11: seeded random traffic against the model
        tag = "R2 R4 R9 R11";
        for (int c = 0; c < 4000; c++) begin
            bit rv = ($urandom % 2) == 0;
            int ri = int'($urandom % N);
            bit rw = ($urandom % 3) == 0;
            bit rq = ($urandom % 5) == 0;
            bit rm = ($urandom % 2) == 0;
            step(rv, ri, rw, rq, rm);
        end
        step(0, 0, 0, 0, 0);
        idle_until_done();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule